// File: doc/BRIEF.md
# Three-Leg Gate Command Guard

This block sits between a PWM generator and the gate drivers of a three-phase half-bridge inverter. For each leg it takes a pair of raw switch requests, one for the upper switch and one for the lower, and turns them into gate commands that are safe to apply to the power stage. Four timing rules are enforced on every leg:

- a dead gap between one switch turning off and its partner turning on;
- a minimum width for every pulse that reaches a gate;
- a ceiling on how long an upper switch may conduct without a break;
- a start-up interlock that keeps an upper switch off until its lower partner has conducted long enough to charge the floating supply of the upper driver.

Requests that break these rules are shortened, delayed or dropped. Each such event is reported on a per-leg fault pulse. A global inhibit input removes every gate command at once and restarts the timing state. All times are parameters counted in clock cycles.

Top module: `tri_leg_gate_guard`

## Requirements
- R1: The upper output `gate_out[2k]` and the lower output `gate_out[2k+1]` of a leg are never high together, whatever the request inputs are.
- R2: A gate output of a leg rises only after both outputs of that leg have been low for at least DEAD_CYC consecutive cycles. The count starts at reset release, at the end of inhibit, or when the other switch turns off.
- R3: Leg k requests its upper switch when `sw_req[2k]=1` and `sw_req[2k+1]=0`, and its lower switch in the opposite case. An output turns on at the clock edge that samples the same single-switch request for the MIN_PULSE-th consecutive time, provided the dead gap (and, for an upper switch, the precharge) is already satisfied.
- R4: Once a gate output is on, it stays on for at least MIN_PULSE cycles, even if the request is removed earlier. Inhibit is the only exception.
- R5: A single-switch request that ends after being sampled on fewer than MIN_PULSE edges produces no output pulse. It sets `leg_fault[k]` for one cycle after the edge that sees the request end.
- R6: If both requests of a leg are high, that leg treats the request as none. Its outputs stay off, and `leg_fault[k]` is high in every cycle after an edge that samples the conflict.
- R7: An upper output that has been on for MAX_HI_ON cycles is forced off and `leg_fault[k]` pulses for one cycle. The upper switch then stays off until its request has been removed.
- R8: After reset or inhibit, an upper output stays off until the lower output of the same leg has been on for BOOT_CYC consecutive cycles.
- R9: While `inhibit` is high, all gate outputs are low in the same cycle, without waiting for a clock edge. Inhibit also clears the precharge state of every leg and restarts the dead gap count.
- R10: During reset and right after it, all gate outputs and fault flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inhibit | input | 1 | Global gate disable; forces all outputs low at once |
| sw_req | input | 2*N_LEGS | Raw requests; bit 2k is the upper switch of leg k, bit 2k+1 the lower switch |
| gate_out | output | 2*N_LEGS | Guarded gate commands, same bit order as `sw_req` |
| leg_fault | output | N_LEGS | Per-leg violation flag (short request dropped, conflicting request, upper on-time limit hit) |

## Verification
The hardest state to reach from the ports is an upper switch actually conducting. That needs a lower pulse that lasts the whole precharge time, then a handover through the dead gap, and no inhibit since then. Only after that can the on-time ceiling and the lockout that follows it be reached.

Directed sequences build this chain explicitly on one leg. They sample the exact cycles of the handover, of the forced turn-off and of the fault pulse. A second chain checks that inhibit discards the precharge and restarts the dead gap.

Random phases then hold requests for up to 60 cycles, which is longer than the bench's on-time ceiling. They also inject occasional conflicting pairs and short inhibit bursts. The port-level monitor checks overlap, dead gap, pulse width and on-time on every edge throughout.

// File: rtl/tlg_pkg.sv
// Shared types for the three-leg gate guard.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package tlg_pkg;

    // Decoded request of one leg after conflict removal.
    typedef enum logic [1:0] {
        W_NONE = 2'd0,
        W_HI   = 2'd1,
        W_LO   = 2'd2
    } want_t;

    // Conduction state of one leg.
    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_HI   = 2'd1,
        LS_LO   = 2'd2
    } leg_state_t;

    // Largest of four timing parameters, used to size counters.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/tlg_req_filter.sv
// Request qualifier for one leg.
// Decodes the raw upper/lower request pair into a single want. A request
// for both switches is a conflict and decodes to none. The module counts
// how many consecutive edges the same want has been sampled, and says when
// that count reaches MIN_PULSE. A want that ends before qualifying gives a
// one-cycle short event.
// Assumes: MIN_PULSE >= 1; CW wide enough to hold MIN_PULSE.
module tlg_req_filter
    import tlg_pkg::*;
#(
    parameter int MIN_PULSE = 3,
    parameter int CW        = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inhibit,
    input  logic  up_req,
    input  logic  dn_req,
    output want_t want,
    output logic  qualified,
    output logic  short_evt,
    output logic  conflict_evt
);
    localparam logic [CW-1:0] MIN_W = CW'(MIN_PULSE);

    want_t         prev_want;
    logic [CW-1:0] run;
    logic [CW-1:0] held;

    // Decode the request pair; both high counts as no request.
    always_comb begin
        if (up_req && !dn_req)      want = W_HI;
        else if (dn_req && !up_req) want = W_LO;
        else                        want = W_NONE;
    end

    // Consecutive sample count including this edge, saturating at MIN_PULSE.
    always_comb begin
        if (want == W_NONE)         held = '0;
        else if (want != prev_want) held = CW'(1);
        else if (run < MIN_W)       held = run + CW'(1);
        else                        held = run;
    end

    assign qualified = (want != W_NONE) && (held >= MIN_W);

    // Track the last want, its run length and the violation events.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            prev_want    <= W_NONE;
            run          <= '0;
            short_evt    <= 1'b0;
            conflict_evt <= 1'b0;
        end else begin
            prev_want    <= want;
            run          <= held;
            short_evt    <= (prev_want != W_NONE) && (want != prev_want) && (run < MIN_W);
            conflict_evt <= up_req && dn_req;
        end
    end

endmodule

// File: rtl/tlg_leg_ctrl.sv
// Conduction controller for one leg.
// Moves between idle, upper-on and lower-on. It enforces the dead gap
// before any turn-on and the minimum on-time before any request-driven
// turn-off. It caps the upper on-time and then locks the upper switch
// until its request drops. The upper switch is held off until the lower
// switch has run BOOT_CYC consecutive cycles. Reset and inhibit clear
// everything.
// Assumes: all timing parameters >= 1; CW holds the largest of them.
module tlg_leg_ctrl
    import tlg_pkg::*;
#(
    parameter int DEAD_CYC  = 4,
    parameter int MIN_PULSE = 3,
    parameter int BOOT_CYC  = 10,
    parameter int MAX_HI_ON = 40,
    parameter int CW        = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inhibit,
    input  want_t want,
    input  logic  qualified,
    output logic  up_on,
    output logic  dn_on,
    output logic  max_evt
);
    localparam logic [CW-1:0] DEAD_M1 = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] MIN_M1  = CW'(MIN_PULSE - 1);
    localparam logic [CW-1:0] BOOT_M1 = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] MAX_M1  = CW'(MAX_HI_ON - 1);
    localparam logic [CW-1:0] CNT_TOP = '1;

    leg_state_t    state;
    logic [CW-1:0] ocnt;
    logic [CW-1:0] dcnt;
    logic          boot_rdy;
    logic          hi_lock;
    logic          dead_ok;
    logic [CW-1:0] ocnt_inc;

    assign dead_ok  = (dcnt >= DEAD_M1);
    assign ocnt_inc = (ocnt == CNT_TOP) ? ocnt : ocnt + CW'(1);
    assign up_on    = (state == LS_HI);
    assign dn_on    = (state == LS_LO);

    // Leg state machine with dead gap, width, ceiling and precharge rules.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            state    <= LS_IDLE;
            ocnt     <= '0;
            dcnt     <= '0;
            boot_rdy <= 1'b0;
            hi_lock  <= 1'b0;
            max_evt  <= 1'b0;
        end else begin
            max_evt <= 1'b0;
            if (want != W_HI) hi_lock <= 1'b0;
            case (state)
                LS_IDLE: begin
                    if (dcnt != CNT_TOP) dcnt <= dcnt + CW'(1);
                    if (qualified && dead_ok) begin
                        if (want == W_LO) begin
                            state <= LS_LO;
                            ocnt  <= '0;
                        end else if (want == W_HI && boot_rdy && !hi_lock) begin
                            state <= LS_HI;
                            ocnt  <= '0;
                        end
                    end
                end
                LS_LO: begin
                    ocnt <= ocnt_inc;
                    if (ocnt >= BOOT_M1) boot_rdy <= 1'b1;
                    if (ocnt >= MIN_M1 && want != W_LO) begin
                        state <= LS_IDLE;
                        dcnt  <= '0;
                    end
                end
                LS_HI: begin
                    ocnt <= ocnt_inc;
                    if (ocnt >= MAX_M1) begin
                        state   <= LS_IDLE;
                        dcnt    <= '0;
                        hi_lock <= 1'b1;
                        max_evt <= 1'b1;
                    end else if (ocnt >= MIN_M1 && want != W_HI) begin
                        state <= LS_IDLE;
                        dcnt  <= '0;
                    end
                end
                default: state <= LS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tri_leg_gate_guard.sv
// Top of the gate guard: one request filter and one leg controller per leg.
// The inhibit input gates every output combinationally, so gates drop in
// the same cycle. The controllers clear their state on the next edge.
// Assumes: sw_req is synchronous to clk; bit 2k upper, bit 2k+1 lower.
module tri_leg_gate_guard
    import tlg_pkg::*;
#(
    parameter int N_LEGS    = 3,
    parameter int DEAD_CYC  = 500,
    parameter int MIN_PULSE = 200,
    parameter int BOOT_CYC  = 10000,
    parameter int MAX_HI_ON = 4000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inhibit,
    input  logic [2*N_LEGS-1:0] sw_req,
    output logic [2*N_LEGS-1:0] gate_out,
    output logic [N_LEGS-1:0]   leg_fault
);
    localparam int TOP_CNT = max4(DEAD_CYC, MIN_PULSE, BOOT_CYC, MAX_HI_ON);
    localparam int CW      = $clog2(TOP_CNT + 1) + 1;

    for (genvar k = 0; k < N_LEGS; k++) begin : g_leg
        want_t want;
        logic  qual;
        logic  short_evt;
        logic  conf_evt;
        logic  up_on;
        logic  dn_on;
        logic  max_evt;

        tlg_req_filter #(
            .MIN_PULSE (MIN_PULSE),
            .CW        (CW)
        ) u_filt (
            .clk          (clk),
            .rst_n        (rst_n),
            .inhibit      (inhibit),
            .up_req       (sw_req[2*k]),
            .dn_req       (sw_req[2*k+1]),
            .want         (want),
            .qualified    (qual),
            .short_evt    (short_evt),
            .conflict_evt (conf_evt)
        );

        tlg_leg_ctrl #(
            .DEAD_CYC  (DEAD_CYC),
            .MIN_PULSE (MIN_PULSE),
            .BOOT_CYC  (BOOT_CYC),
            .MAX_HI_ON (MAX_HI_ON),
            .CW        (CW)
        ) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .inhibit   (inhibit),
            .want      (want),
            .qualified (qual),
            .up_on     (up_on),
            .dn_on     (dn_on),
            .max_evt   (max_evt)
        );

        // Gate outputs drop at once under inhibit; fault merges the events.
        assign gate_out[2*k]   = up_on & ~inhibit;
        assign gate_out[2*k+1] = dn_on & ~inhibit;
        assign leg_fault[k]    = short_evt | conf_evt | max_evt;
    end

endmodule

// File: rtl/tlg_guard_chk.sv
// Port-level checker for the gate guard, bound to the top module.
// It keeps its own per-leg run counters of the observed outputs and
// checks the timing rules against them.
// Assumes: same parameters as the bound top instance.
module tlg_guard_chk
    import tlg_pkg::*;
#(
    parameter int N_LEGS    = 3,
    parameter int DEAD_CYC  = 4,
    parameter int MIN_PULSE = 3,
    parameter int BOOT_CYC  = 10,
    parameter int MAX_HI_ON = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                inhibit,
    input logic [2*N_LEGS-1:0] gate_out
);
    localparam int            CW      = $clog2(max4(DEAD_CYC, MIN_PULSE, BOOT_CYC, MAX_HI_ON) + 1) + 1;
    localparam logic [CW-1:0] DEAD_W  = CW'(DEAD_CYC);
    localparam logic [CW-1:0] MIN_W   = CW'(MIN_PULSE);
    localparam logic [CW-1:0] BOOT_M1 = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] MAX_W   = CW'(MAX_HI_ON);
    localparam logic [CW-1:0] TOP     = '1;

    // R9: inhibit removes every gate in the same cycle
    assert_inhibit_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (gate_out == '0));

    for (genvar k = 0; k < N_LEGS; k++) begin : g_chk
        logic          hi, lo, hi_q, lo_q, boot_seen;
        logic [CW-1:0] off_run, hi_run, lo_run;

        assign hi = gate_out[2*k];
        assign lo = gate_out[2*k+1];

        // Track prior-sample run lengths and observed precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q      <= 1'b0;
                lo_q      <= 1'b0;
                off_run   <= '0;
                hi_run    <= '0;
                lo_run    <= '0;
                boot_seen <= 1'b0;
            end else begin
                hi_q    <= hi;
                lo_q    <= lo;
                off_run <= (hi || lo) ? '0 : ((off_run == TOP) ? off_run : off_run + CW'(1));
                hi_run  <= !hi ? '0 : ((hi_run == TOP) ? hi_run : hi_run + CW'(1));
                lo_run  <= !lo ? '0 : ((lo_run == TOP) ? lo_run : lo_run + CW'(1));
                if (inhibit)                        boot_seen <= 1'b0;
                else if (lo && lo_run >= BOOT_M1)   boot_seen <= 1'b1;
            end
        end

        assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi && lo));
        assert_dead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((hi && !hi_q) || (lo && !lo_q)) |-> (off_run >= DEAD_W));
        assert_min_width_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!hi && hi_q && !inhibit) |-> (hi_run >= MIN_W));
        assert_min_width_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!lo && lo_q && !inhibit) |-> (lo_run >= MIN_W));
        assert_max_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hi |-> (hi_run < MAX_W));
        assert_precharge_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hi && !hi_q) |-> boot_seen);
    end

endmodule

bind tri_leg_gate_guard tlg_guard_chk #(
    .N_LEGS    (N_LEGS),
    .DEAD_CYC  (DEAD_CYC),
    .MIN_PULSE (MIN_PULSE),
    .BOOT_CYC  (BOOT_CYC),
    .MAX_HI_ON (MAX_HI_ON)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inhibit  (inhibit),
    .gate_out (gate_out)
);

// File: tb/sim_tri_leg_gate_guard.sv
`timescale 1ns/1ps
module sim_tri_leg_gate_guard;
    localparam int NL    = 3;
    localparam int DEAD  = 4;
    localparam int MINP  = 3;
    localparam int BOOT  = 10;
    localparam int MAXHI = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inh = 1'b0;
    logic [5:0]    req = '0;
    logic [5:0]    gate;
    logic [2:0]    fault;
    int            n_chk = 0;
    int            n_err = 0;
    bit            mon_en = 1'b0;
    bit            done = 1'b0;
    int            off_run [3];
    int            hi_run [3];
    int            lo_run [3];
    logic [5:0]    gq = '0;

    always #2.5 clk = ~clk;

    tri_leg_gate_guard #(
        .N_LEGS(NL), .DEAD_CYC(DEAD), .MIN_PULSE(MINP),
        .BOOT_CYC(BOOT), .MAX_HI_ON(MAXHI)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .inhibit(inh),
        .sw_req(req), .gate_out(gate), .leg_fault(fault)
    );

    // Expected-value helpers derived from the requirements.
    function automatic bit gap_ok(int off);   return off >= DEAD;  endfunction
    function automatic bit width_ok(int run); return run >= MINP;  endfunction
    function automatic bit ceil_ok(int run);  return run <= MAXHI; endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_ok(string tag, bit ok, int act, string exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected %s", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    // Port monitor: overlap, dead gap, width and ceiling on every sample.
    always @(negedge clk) begin
        if (mon_en) begin
            for (int k = 0; k < NL; k++) begin
                check_eq("R1 leg overlap", {31'd0, gate[2*k] & gate[2*k+1]}, 0);
                if ((gate[2*k] && !gq[2*k]) || (gate[2*k+1] && !gq[2*k+1]))
                    check_ok("R2 dead gap before rise", gap_ok(off_run[k]), off_run[k], ">= DEAD");
                if (!inh && !gate[2*k] && gq[2*k])
                    check_ok("R4 upper width", width_ok(hi_run[k]), hi_run[k], ">= MIN");
                if (!inh && !gate[2*k+1] && gq[2*k+1])
                    check_ok("R4 lower width", width_ok(lo_run[k]), lo_run[k], ">= MIN");
                if (gate[2*k])
                    check_ok("R7 upper ceiling", ceil_ok(hi_run[k] + 1), hi_run[k] + 1, "<= MAX");
                off_run[k] = (gate[2*k] || gate[2*k+1]) ? 0 : off_run[k] + 1;
                hi_run[k]  = gate[2*k]   ? hi_run[k] + 1 : 0;
                lo_run[k]  = gate[2*k+1] ? lo_run[k] + 1 : 0;
            end
            gq = gate;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        int hold [3];
        int inh_hold;
        void'($urandom(32'd1234));
        for (int k = 0; k < NL; k++) begin
            off_run[k] = 0; hi_run[k] = 0; lo_run[k] = 0; hold[k] = 0;
        end
        ticks(3);
        check_eq("R10 gates in reset", gate, 0);
        check_eq("R10 faults in reset", fault, 0);
        #1 rst_n = 1'b1; mon_en = 1'b1;
        ticks(1);
        check_eq("R10 gates after reset", gate, 0);

        // R8: upper request with no precharge never reaches the gate
        #1 req = 6'b000100;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += gate[2]; end
        check_eq("R8 upper blocked before precharge", cnt, 0);
        #1 req = '0;
        ticks(6);

        // R3: lower on at the MIN-th sampling edge
        #1 req = 6'b000010;
        ticks(2);
        check_eq("R3 lower not yet on", gate[1], 0);
        ticks(1);
        check_eq("R3 lower on at qualifying edge", gate[1], 1);
        ticks(12);
        #1 req = 6'b000001;
        ticks(1);
        check_eq("R2 lower off on handover", gate[1:0], 0);
        ticks(3);
        check_eq("R2 upper held in dead gap", gate[0], 0);
        ticks(1);
        check_eq("R8 upper on after precharge and gap", gate[0], 1);

        // R7: ceiling, fault pulse, lockout
        ticks(39);
        check_eq("R7 upper still on before ceiling", gate[0], 1);
        ticks(1);
        check_eq("R7 upper forced off", gate[0], 0);
        check_eq("R7 fault pulse", fault[0], 1);
        ticks(1);
        check_eq("R7 fault one cycle", fault[0], 0);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += gate[0]; end
        check_eq("R7 upper locked while request held", cnt, 0);
        #1 req = '0;
        ticks(6);

        // R5: a two-edge lower request is dropped and flagged
        #1 req = 6'b100000;
        cnt = 0;
        ticks(1); cnt += gate[5];
        ticks(1); cnt += gate[5];
        #1 req = '0;
        ticks(1); cnt += gate[5];
        check_eq("R5 short request flagged", fault[2], 1);
        check_eq("R5 short request produced no pulse", cnt, 0);
        ticks(6);

        // R4: a request of exactly MIN edges yields a pulse of MIN cycles
        #1 req = 6'b100000;
        ticks(3);
        check_eq("R4 lower on", gate[5], 1);
        #1 req = '0;
        ticks(1);
        check_eq("R5 qualified request not flagged", fault[2], 0);
        ticks(1);
        check_eq("R4 lower held after request gone", gate[5], 1);
        ticks(1);
        check_eq("R4 lower off after min width", gate[5], 0);
        ticks(6);

        // R6: both requests give no output and a fault
        #1 req = 6'b110000;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += gate[5] + gate[4]; end
        check_eq("R6 conflict gives no gate", cnt, 0);
        check_eq("R6 conflict fault", fault[2], 1);
        #1 req = '0;
        ticks(6);

        // R9: inhibit drops gates at once, clears precharge, restarts gap
        #1 req = 6'b001000;
        ticks(3);
        check_eq("R3 leg1 lower on", gate[3], 1);
        ticks(12);
        #1 req = 6'b000100;
        ticks(5);
        check_eq("R8 leg1 upper on after precharge", gate[2], 1);
        #1 inh = 1'b1;
        #1 check_eq("R9 gates low in same cycle", gate, 0);
        ticks(3);
        #1 inh = 1'b0; req = 6'b000110;
        cnt = 0;
        ticks(3); cnt += gate[2];
        check_eq("R9 dead gap restarted after inhibit", gate[1], 0);
        ticks(1); cnt += gate[2];
        check_eq("R9 lower on after restarted gap", gate[1], 1);
        for (int i = 0; i < 26; i++) begin @(negedge clk); cnt += gate[2]; end
        check_eq("R9 precharge cleared by inhibit", cnt, 0);
        #1 req = '0;
        ticks(8);

        // Random phase: held requests, conflicts and inhibit bursts
        inh_hold = 0;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            #1;
            for (int k = 0; k < NL; k++) begin
                if (hold[k] == 0) begin
                    int r;
                    r = int'($urandom % 8);
                    hold[k] = 1 + int'($urandom % 60);
                    if (r < 3)      req[2*k +: 2] = 2'b00;
                    else if (r < 5) req[2*k +: 2] = 2'b01;
                    else if (r < 7) req[2*k +: 2] = 2'b10;
                    else            req[2*k +: 2] = 2'b11;
                end else begin
                    hold[k]--;
                end
            end
            if (inh_hold > 0) begin
                inh_hold--;
                if (inh_hold == 0) inh = 1'b0;
            end else if (($urandom % 700) == 0) begin
                inh = 1'b1;
                inh_hold = 1 + int'($urandom % 4);
            end
        end
        #1 req = '0; inh = 1'b0;
        ticks(10);
        check_eq("R1 all idle at end", gate, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule